// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block models a small serial EEPROM that holds 256 words of 16 bits. It sits behind a single memory-mapped register. Software drives the device pins one write at a time: chip select, serial clock and serial data-in. It reads the serial data-out line back from the same register offset. Each accepted register write is compared with the previous accepted write. A rising or falling edge on chip select or clock then moves a protocol state machine that decodes a start bit, a 2-bit opcode, an 8-bit address and, for some commands, 16 data bits.

Commands cover single-word read, write and erase, plus whole-array write and erase. Two special functions enable or disable writes, and that write-protect latch gates every change to storage. A single-word write or erase is committed only on the chip-select rising edge that follows the data. Between commands the data-out line reads high, which tells software the device is ready. Register offsets outside the selected one belong to other functions and read back as all ones.

Top module: `serial_eeprom_port`

## Requirements
- R1: After reset, writes are disabled, storage words all hold 0xFFFF, and a read at the device offset returns 0x01 (ready).
- R2: Only a write whose address bits 7:4 equal 0x8 is accepted. In the written byte, chip select is bit 7, clock is bit 6 and data-in is bit 1. Edges are taken against the pins of the previous accepted write, and writes at any other offset change nothing.
- R3: A read whose address bits 7:4 equal 0x8 returns data-out in bit 0 with bits 7:1 zero. A read at any other offset returns 0xFF.
- R4: A chip-select rising edge while a write is pending stores the shifted data, if writes are enabled, and the port then reads 0x01. In any other state the edge abandons the frame and waits for a start bit.
- R5: While waiting for a start bit, a clock rising edge with data-in 1 starts a frame and clears the shift register, so data-out reads 0. Two opcode bits and then eight address bits follow, most significant bit first.
- R6: Opcode 00 with address bits 7:6 = 11 enables writes, and with 00 disables them. Either takes effect at the eighth address clock.
- R7: Opcode 01 collects 16 data bits, most significant first, and stores them to the addressed word on the next chip-select rising edge.
- R8: Opcode 10 loads the addressed word after one dummy clock rising edge, and data-out then reads 0. Each following clock falling edge presents the next bit, most significant first. After 16 falling edges the frame ends.
- R9: Opcode 11 sets the addressed word to 0xFFFF on the chip-select rising edge that follows 16 clocks.
- R10: Opcode 00 with address bits 7:6 = 01 writes the next 16 data bits to every word. With 10, it sets every word to 0xFFFF. The array changes at the sixteenth clock rising edge.
- R11: While writes are disabled, no command changes any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 8 | Low byte of the register write address |
| wrData | input | 8 | Written byte carrying the pin levels |
| rdAddr | input | 8 | Low byte of the register read address |
| rdData | output | 8 | Read byte; data-out in bit 0 at the device offset |

## Verification
An accepted write changes the control and shift state at the clock edge on which its strobe is sampled. The read port is combinational, so each result is due one cycle after the strobe. The bench drives every strobe on a falling edge for exactly one cycle. It then records the expected read byte at the next falling edge, and the monitor compares it a nanosecond later, after the update edge and before the next stimulus. Storage results such as commits, fills and protected writes are observed through later read frames, and each of those bits is due on the cycle after its own clock-falling write.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

  localparam int DefWordW = 16;
  localparam int DefAddrW = 8;

  typedef enum logic [3:0] {
    StNull,
    StIdle,
    StOpcode,
    StAddr,
    StSpecial,
    StCollect,
    StFetch,
    StErase,
    StRead,
    StWrite
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic clearSr;
    logic loadReady;
    logic loadOnes;
    logic loadWord;
    logic latchAddr;
    logic commitWord;
    logic fillAll;
    logic eraseAll;
  } dpStrobes_t;

endpackage

// File: rtl/serial_eeprom_ctrl.sv
module serial_eeprom_ctrl
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_W = DefWordW,
  parameter int ADDR_W = DefAddrW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accept,
  input  logic              csPin,
  input  logic              skPin,
  input  logic              diPin,
  input  logic [ADDR_W-1:0] shiftedLow,
  input  logic [1:0]        addrFunc,
  output dpStrobes_t        strb
);

  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam int OP_W  = 2;
  localparam logic [CNT_W-1:0] OpCount   = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] AddrCount = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] DataCount = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OneCount  = CNT_W'(1);

  ctrlState_t       state, stateNext, stateMid;
  logic [CNT_W-1:0] bitCnt, cntNext, cntShift;
  logic [OP_W-1:0]  opcode, opNext;
  logic             wpEn, wpNext;
  logic             prevCs, prevSk;
  logic             csRise, skRise, skFall;
  logic             shiftOn;

  assign csRise = csPin && !prevCs;
  assign skRise = skPin && !prevSk;
  assign skFall = !skPin && prevSk;

  always_comb begin
    stateNext = state;
    stateMid  = state;
    cntNext   = bitCnt;
    cntShift  = bitCnt;
    opNext    = opcode;
    wpNext    = wpEn;
    shiftOn   = 1'b0;
    strb      = '0;
    if (accept) begin
      if (csRise) begin
        if (state == StWrite) begin
          strb.commitWord = wpEn;
          strb.loadReady  = 1'b1;
          stateMid        = StNull;
        end else begin
          stateMid = StIdle;
        end
      end
      stateNext = stateMid;
      if (skRise) begin
        shiftOn      = (stateMid != StNull) && (stateMid != StIdle) && (stateMid != StRead);
        strb.shiftIn = shiftOn;
        cntShift     = shiftOn ? bitCnt + OneCount : bitCnt;
        cntNext      = cntShift;
        case (stateMid)
          StIdle: begin
            if (diPin) begin
              stateNext    = StOpcode;
              cntNext      = '0;
              strb.clearSr = 1'b1;
            end
          end
          StOpcode: begin
            if (cntShift == OpCount) begin
              stateNext = StAddr;
              cntNext   = '0;
              opNext    = shiftedLow[OP_W-1:0];
            end
          end
          StAddr: begin
            if (cntShift == AddrCount) begin
              cntNext        = '0;
              strb.latchAddr = 1'b1;
              case (opcode)
                2'd0: begin
                  case (shiftedLow[ADDR_W-1 -: 2])
                    2'b00: begin
                      wpNext    = 1'b0;
                      stateNext = StNull;
                    end
                    2'b11: begin
                      wpNext    = 1'b1;
                      stateNext = StNull;
                    end
                    default: stateNext = StSpecial;
                  endcase
                end
                2'd1:    stateNext = StCollect;
                2'd2:    stateNext = StFetch;
                default: stateNext = StErase;
              endcase
            end
          end
          StSpecial: begin
            if (cntShift == DataCount) begin
              case (addrFunc)
                2'b01: begin
                  strb.fillAll = wpEn;
                  stateNext    = StWrite;
                end
                2'b10: begin
                  strb.eraseAll = wpEn;
                  stateNext     = StWrite;
                end
                default: stateNext = StNull;
              endcase
            end
          end
          StCollect: begin
            if (cntShift == DataCount) begin
              cntNext   = '0;
              stateNext = StWrite;
            end
          end
          StFetch: begin
            if (cntShift == OneCount) begin
              strb.loadWord = 1'b1;
              cntNext       = '0;
              stateNext     = StRead;
            end
          end
          StErase: begin
            if (cntShift == DataCount) begin
              strb.loadOnes = 1'b1;
              cntNext       = '0;
              stateNext     = StWrite;
            end
          end
          default: ;
        endcase
      end else if (skFall && stateMid == StRead) begin
        strb.shiftOut = 1'b1;
        cntNext       = bitCnt + OneCount;
        if (bitCnt + OneCount == DataCount) begin
          cntNext   = '0;
          stateNext = StNull;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= StNull;
      bitCnt <= '0;
      opcode <= '0;
      wpEn   <= 1'b0;
      prevCs <= 1'b0;
      prevSk <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= cntNext;
      opcode <= opNext;
      wpEn   <= wpNext;
      if (accept) begin
        prevCs <= csPin;
        prevSk <= skPin;
      end
    end
  end

  a_r2_offset_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> ($stable(state) && $stable(wpEn) && $stable(bitCnt)));

  a_r4_commit_to_null: assert property (@(posedge clk) disable iff (!rstN)
    (accept && csRise && state == StWrite) |=> (state == StNull));

  a_r8_read_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (state == StRead) |-> (bitCnt < DataCount));

  a_r6_enable_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wpEn) |-> ($past(state) == StAddr));

endmodule

// File: rtl/serial_eeprom_dp.sv
module serial_eeprom_dp
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_W = DefWordW,
  parameter int ADDR_W = DefAddrW
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              diPin,
  output logic [ADDR_W-1:0] shiftedLow,
  output logic [1:0]        addrFunc,
  output logic              dataOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SR_W  = WORD_W + 1;
  localparam logic [SR_W-1:0] ReadyVal = '1;
  localparam logic [SR_W-1:0] OnesVal  = {1'b0, {WORD_W{1'b1}}};

  logic [SR_W-1:0]   sr;
  logic [SR_W-1:0]   srShifted;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] mem [DEPTH];

  assign srShifted  = {sr[WORD_W-1:0], diPin};
  assign shiftedLow = srShifted[ADDR_W-1:0];
  assign addrFunc   = addrReg[ADDR_W-1 -: 2];
  assign dataOut    = sr[SR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr <= ReadyVal;
    end else if (strb.loadWord) begin
      sr <= {1'b0, mem[addrReg]};
    end else if (strb.loadOnes) begin
      sr <= OnesVal;
    end else if (strb.clearSr) begin
      sr <= '0;
    end else if (strb.loadReady) begin
      sr <= ReadyVal;
    end else if (strb.shiftIn) begin
      sr <= srShifted;
    end else if (strb.shiftOut) begin
      sr <= {sr[WORD_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.latchAddr) begin
      addrReg <= shiftedLow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.fillAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= srShifted[WORD_W-1:0];
    end else if (strb.commitWord) begin
      mem[addrReg] <= sr[WORD_W-1:0];
    end
  end

  a_r4_ready_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadReady |=> (dataOut && sr == ReadyVal));

  a_r8_fetch_leading_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> !dataOut);

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearSr |=> (sr == '0));

endmodule

// File: rtl/serial_eeprom_port.sv
module serial_eeprom_port
  import serial_eeprom_pkg::*;
#(
  parameter int         WORD_W  = DefWordW,
  parameter int         ADDR_W  = DefAddrW,
  parameter logic [3:0] SEL_NIB = 4'h8,
  parameter int         CS_BIT  = 7,
  parameter int         SK_BIT  = 6,
  parameter int         DI_BIT  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStrobe,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [7:0] rdAddr,
  output logic [7:0] rdData
);

  dpStrobes_t        strb;
  logic              accept;
  logic [ADDR_W-1:0] shiftedLow;
  logic [1:0]        addrFunc;
  logic              dataOut;

  assign accept = wrStrobe && (wrAddr[7:4] == SEL_NIB);
  assign rdData = (rdAddr[7:4] == SEL_NIB) ? {7'b0, dataOut} : 8'hFF;

  serial_eeprom_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accept     (accept),
    .csPin      (wrData[CS_BIT]),
    .skPin      (wrData[SK_BIT]),
    .diPin      (wrData[DI_BIT]),
    .shiftedLow (shiftedLow),
    .addrFunc   (addrFunc),
    .strb       (strb)
  );

  serial_eeprom_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .diPin      (wrData[DI_BIT]),
    .shiftedLow (shiftedLow),
    .addrFunc   (addrFunc),
    .dataOut    (dataOut)
  );

endmodule

// File: tb/serial_eeprom_port_tb.sv
module serial_eeprom_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrAddr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdAddr = 8'h80;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  expVals[$];
  string       expTags[$];
  logic [15:0] model[256];
  bit          wpModel;

  always #5 clk = ~clk;

  serial_eeprom_port u_dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expVals.size() > 0) begin
        logic [7:0] ev;
        string tg;
        ev = expVals.pop_front();
        tg = expTags.pop_front();
        checks++;
        if (rdData !== ev) begin
          fails++;
          $display("FAIL %s: rdData=%h expected=%h", tg, rdData, ev);
        end
      end
    end
  end

  task automatic expectRd(input logic [7:0] v, input string tag);
    expVals.push_back(v);
    expTags.push_back(tag);
  endtask

  task automatic rawWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic pinWr(input bit cs, input bit sk, input bit di);
    rawWr(8'h80, {cs, sk, 4'b0, di, 1'b0});
  endtask

  task automatic sendBit(input bit b);
    pinWr(1'b1, 1'b0, b);
    pinWr(1'b1, 1'b1, b);
  endtask

  task automatic beginFrame();
    pinWr(1'b0, 1'b0, 1'b0);
    pinWr(1'b1, 1'b0, 1'b0);
  endtask

  task automatic frameHead(input logic [1:0] op, input logic [7:0] a);
    beginFrame();
    sendBit(1'b1);
    sendBit(op[1]);
    sendBit(op[0]);
    for (int i = 7; i >= 0; i--) sendBit(a[i]);
  endtask

  task automatic sendWord(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) sendBit(d[i]);
  endtask

  task automatic cmdEnable(input bit en);
    frameHead(2'b00, en ? 8'hC0 : 8'h00);
    wpModel = en;
  endtask

  task automatic cmdWrite(input logic [7:0] a, input logic [15:0] d);
    frameHead(2'b01, a);
    sendWord(d);
    beginFrame();
    expectRd(8'h01, "R4 ready after write commit");
    if (wpModel) model[a] = d;
  endtask

  task automatic cmdErase(input logic [7:0] a);
    frameHead(2'b11, a);
    sendWord(16'hFFFF);
    beginFrame();
    expectRd(8'h01, "R9 ready after erase commit");
    if (wpModel) model[a] = 16'hFFFF;
  endtask

  task automatic cmdFill(input logic [15:0] d);
    frameHead(2'b00, 8'h40);
    sendWord(d);
    beginFrame();
    if (wpModel) for (int i = 0; i < 256; i++) model[i] = d;
  endtask

  task automatic cmdEraseAll();
    frameHead(2'b00, 8'h80);
    sendWord(16'hFFFF);
    beginFrame();
    if (wpModel) for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
  endtask

  task automatic cmdRead(input logic [7:0] a, input string tag);
    frameHead(2'b10, a);
    pinWr(1'b1, 1'b0, 1'b0);
    pinWr(1'b1, 1'b1, 1'b0);
    expectRd(8'h00, "R8 dummy clock gives 0");
    for (int i = 15; i >= 0; i--) begin
      pinWr(1'b1, 1'b0, 1'b0);
      expectRd({7'b0, model[a][i]}, tag);
      pinWr(1'b1, 1'b1, 1'b0);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    wpModel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectRd(8'h01, "R1 ready after reset");
    @(negedge clk);
    rdAddr = 8'h20;
    expectRd(8'hFF, "R3 other offset reads FF");
    @(negedge clk);
    rdAddr = 8'h8C;
    expectRd(8'h01, "R3 device offset bits 7:1 zero");
    @(negedge clk);
    rdAddr = 8'h80;

    cmdRead(8'h05, "R1 reset storage 0xFFFF");

    // writes disabled after reset: write is dropped
    cmdWrite(8'h05, 16'h1234);
    cmdRead(8'h05, "R11 protected write dropped");

    cmdEnable(1'b1);
    cmdWrite(8'h05, 16'hA5C3);
    cmdRead(8'h05, "R7 word written and read back");
    cmdWrite(8'hFF, 16'h0001);
    cmdRead(8'hFF, "R7 top address word");
    cmdRead(8'h05, "R6 enable kept");

    cmdErase(8'h05);
    cmdRead(8'h05, "R9 word erased");

    // R2: writes at other offsets do nothing
    beginFrame();
    expectRd(8'h01, "R2 idle still ready");
    rawWr(8'h40, 8'hC2);
    rawWr(8'h90, 8'h00);
    rawWr(8'h7F, 8'hC2);
    expectRd(8'h01, "R2 foreign offsets ignored");
    pinWr(1'b1, 1'b1, 1'b1);
    expectRd(8'h00, "R5 start bit clears register");

    // R4: abort a write frame midway
    cmdWrite(8'h09, 16'h7777);
    frameHead(2'b01, 8'h09);
    for (int i = 0; i < 8; i++) sendBit(1'b0);
    beginFrame();
    cmdRead(8'h09, "R4 aborted frame leaves word");

    cmdFill(16'h5A5A);
    cmdRead(8'h00, "R10 write-all word 0");
    cmdRead(8'hC8, "R10 write-all word C8");

    cmdEraseAll();
    cmdRead(8'hC8, "R10 erase-all");

    cmdEnable(1'b0);
    cmdFill(16'h1357);
    cmdWrite(8'h03, 16'h2468);
    cmdRead(8'h03, "R11 disabled fill and write dropped");
    cmdRead(8'h44, "R6 disable stops write-all");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule